// File: doc/BRIEF.md
# Feedforward Shared Adder-Subtracter FFT Stage

This block is one radix-2 stage of a pipelined FFT that accepts a single complex sample per clock. It pairs each sample with the sample `HALF_LEN` positions later in the same block of `2*HALF_LEN` samples. It then delivers first the halved sums of all pairs and then their halved differences. The stage has no separate adder and subtracter. It uses one complex adder-subtracter that alternates between the two jobs. Two feedforward delay lines, each `HALF_LEN` samples deep, feed it through operand multiplexers.

The output order matches that of a delay-feedback radix-2 stage of the same length, so both kinds of stage can sit in one pipeline and share one sample counter. Per block, the `HALF_LEN` sums come out while the second half of the block enters. The `HALF_LEN` differences come out while the first half of the following block enters. The phase input is one bit of a shared down-counting sample counter. It is high during the first half of each block and drives the adder's carry-in directly, without an inverter. Each result is shifted right arithmetically by one and truncated, so the data width stays constant. Twiddle multiplication and reordering belong to neighbouring blocks.

Top module: `sff_stage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_re`/`out_im` are 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `out_re` and `out_im` keep their previous values on the next cycle.
- R3: For an accepted sample with `first_half` = 0, the next output is floor((x[n-HALF_LEN] + x[n]) / 2), where indices count accepted samples only.
- R4: For an accepted sample with `first_half` = 1, the next output is floor((x[n-2*HALF_LEN] - x[n-HALF_LEN]) / 2). This is the difference of the pair from the previous block.
- R5: With `first_half` taken as bit log2(HALF_LEN) of a counter that counts accepted samples downwards from all ones, each block yields `HALF_LEN` sums in pair order and then, during the next block, `HALF_LEN` differences in the same pair order.
- R6: Full-scale operands never wrap. For example, 32767 + 32767 gives 32767, and -32768 - 32767 gives -32768 (with DATA_W = 16).
- R7: Halving rounds toward minus infinity. For example, -1 + 0 gives -1, and 1 + 0 gives 0.
- R8: Cycles with `in_valid` = 0 move neither delay line, so gaps in the input stream do not change which samples are paired.
- R9: Real and imaginary parts are computed independently, with identical arithmetic.
- R10: The behaviour of R3 and R4 holds both for delay lines no longer than `SRL_MAX` (register chain) and for longer ones (synchronous memory with read-before-write), for example HALF_LEN = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier; also advances the delay lines |
| first_half | input | 1 | 1 while the first half of a 2*HALF_LEN block enters (selects difference) |
| in_re | input | DATA_W | Real part of the input, two's complement |
| in_im | input | DATA_W | Imaginary part of the input, two's complement |
| out_valid | output | 1 | Registered output qualifier |
| out_re | output | DATA_W | Real part of the halved sum or difference |
| out_im | output | DATA_W | Imaginary part of the halved sum or difference |

## Verification
A delay line of the wrong length, or one that advances on idle cycles, pairs the wrong samples. This shows as a wrong sum on the first second-half sample of the first full block, or on the first sample after a gap. A wrong operand selection or carry polarity shows within one cycle of the phase bit changing. Sums and differences either swap or come out off by one. Overflow and rounding faults only show on full-scale and small negative operands, so the sweep includes runs of extreme values and runs of values near zero. It covers delay lengths 1, 2, 4, 8 and 32, so that both delay-line variants are exercised.

// File: rtl/sff_pkg.sv
package sff_pkg;
  // Operation of the shared adder-subtracter; the encoding is the carry-in.
  typedef enum logic {
    OP_SUM  = 1'b0,
    OP_DIFF = 1'b1
  } op_e;

  // Number of parts per complex sample (real, imaginary).
  localparam int NPARTS = 2;
endpackage

// File: rtl/sff_delay_line.sv
// Sample delay of DEPTH accepted inputs. Short delays use a register chain;
// long delays use a read-before-write memory plus one output register.
module sff_delay_line #(
  parameter int W       = 32,
  parameter int DEPTH   = 8,
  parameter int SRL_MAX = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH <= SRL_MAX) begin : g_chain
      logic [W-1:0] taps [DEPTH];
      always_ff @(posedge clk) begin
        if (en) begin
          taps[0] <= din;
          for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
      end
      assign dout = taps[DEPTH-1];
    end else begin : g_mem
      localparam int RD = DEPTH - 1;
      localparam int AW = (RD > 1) ? $clog2(RD) : 1;
      logic [W-1:0]  mem [RD];
      logic [W-1:0]  rd_q;
      logic [AW-1:0] ptr;
      always_ff @(posedge clk) begin
        if (en) begin
          rd_q     <= mem[ptr];
          mem[ptr] <= din;
        end
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          ptr <= '0;
        end else if (en) begin
          ptr <= (ptr == AW'(RD - 1)) ? '0 : ptr + 1'b1;
        end
      end
      assign dout = rd_q;
    end
  endgenerate
endmodule

// File: rtl/sff_addsub.sv
// One part of the shared adder-subtracter: a + b or a - b at W+1 bits,
// then halved and truncated back to W bits.
module sff_addsub
  import sff_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e                 op,
  input  logic signed [W-1:0] opa,
  input  logic signed [W-1:0] opb,
  output logic signed [W-1:0] res
);
  logic signed [W:0] ext_a;
  logic signed [W:0] ext_b;
  logic signed [W:0] full;
  logic              cin;

  always_comb begin
    cin   = op;
    ext_a = {opa[W-1], opa};
    ext_b = cin ? ~{opb[W-1], opb} : {opb[W-1], opb};
    full  = ext_a + ext_b + {{W{1'b0}}, cin};
    res   = full[W:1];
  end
endmodule

// File: rtl/sff_stage.sv
// Radix-2 feedforward FFT stage with a single time-shared adder-subtracter.
module sff_stage
  import sff_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int HALF_LEN = 8,
  parameter int SRL_MAX  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     first_half,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  localparam int CW = NPARTS * DATA_W;

  logic [CW-1:0] din;
  logic [CW-1:0] a_q;
  logic [CW-1:0] b_q;
  logic [CW-1:0] opa;
  logic [CW-1:0] opb;
  logic [CW-1:0] res;
  op_e           op;

  logic signed [DATA_W-1:0] a_re;
  logic signed [DATA_W-1:0] b_re;

  assign din  = {in_im, in_re};
  assign a_re = a_q[DATA_W-1:0];
  assign b_re = b_q[DATA_W-1:0];

  sff_delay_line #(.W(CW), .DEPTH(HALF_LEN), .SRL_MAX(SRL_MAX)) dly_a_i (
    .clk(clk), .rst(rst), .en(in_valid), .din(din), .dout(a_q)
  );

  sff_delay_line #(.W(CW), .DEPTH(HALF_LEN), .SRL_MAX(SRL_MAX)) dly_b_i (
    .clk(clk), .rst(rst), .en(in_valid), .din(a_q), .dout(b_q)
  );

  // Phase bit goes straight to the carry-in; no inversion on this path.
  assign op = op_e'(first_half);

  // Operand multiplexers: sum uses (delayed, current), difference uses
  // (twice delayed, once delayed).
  always_comb begin
    if (op == OP_DIFF) begin
      opa = b_q;
      opb = a_q;
    end else begin
      opa = a_q;
      opb = din;
    end
  end

  generate
    for (genvar g = 0; g < NPARTS; g++) begin : g_part
      sff_addsub #(.W(DATA_W)) addsub_i (
        .op (op),
        .opa(opa[g*DATA_W +: DATA_W]),
        .opb(opb[g*DATA_W +: DATA_W]),
        .res(res[g*DATA_W +: DATA_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= res[DATA_W-1:0];
        out_im <= res[CW-1:DATA_W];
      end
    end
  end
endmodule

// File: rtl/sff_stage_chk.sv
module sff_stage_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     first_half,
  input logic signed [DATA_W-1:0] in_re,
  input logic signed [DATA_W-1:0] a_re,
  input logic signed [DATA_W-1:0] b_re,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_re,
  input logic signed [DATA_W-1:0] out_im
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_d) begin
      rst_clears_chk : assert (!out_valid && out_re == '0 && out_im == '0)
        else $error("output not cleared by reset");
    end
  end

  // R2
  valid_follow_chk : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

  // R6
  no_overflow_chk : assert property (@(posedge clk) disable iff (rst)
    (in_valid && !first_half && !a_re[DATA_W-1] && !in_re[DATA_W-1])
      |=> !out_re[DATA_W-1]);

  // R4
  equal_pair_diff_chk : assert property (@(posedge clk) disable iff (rst)
    (in_valid && first_half && a_re == b_re) |=> (out_re == '0));
endmodule

bind sff_stage sff_stage_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .first_half(first_half),
  .in_re(in_re), .a_re(a_re), .b_re(b_re),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/sff_stage_tb_top.sv
module sff_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int NL   = 5;
  localparam int NSMP = 700;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;
  logic [NL-1:0] fh = '0;
  logic [NL-1:0] ov;
  logic signed [W-1:0] ore [NL];
  logic signed [W-1:0] oim [NL];

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lane_len(int i);
    return (i == 4) ? 32 : (1 << i);
  endfunction

  function automatic int lane_bit(int i);
    return (i == 4) ? 5 : i;
  endfunction

  generate
    for (genvar i = 0; i < NL; i++) begin : g_lane
      sff_stage #(.DATA_W(W), .HALF_LEN((i == 4) ? 32 : (1 << i)), .SRL_MAX(16)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .first_half(fh[i]),
        .in_re(in_re), .in_im(in_im),
        .out_valid(ov[i]), .out_re(ore[i]), .out_im(oim[i])
      );
    end
  endgenerate

  int xr [NSMP];
  int xi [NSMP];
  int last_re [NL];
  int last_im [NL];

  task automatic check(string tag, int lane, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s (l=%0d): actual %0d expected %0d", tag, lane_len(lane), act, exp);
    end
  endtask

  function automatic string tag_for(int i, int m, bit sum);
    if (i == 4) return "R10";
    if (m >= 400) return "R8";
    if (m >= 300) return "R7";
    if (m >= 200) return "R6";
    return sum ? "R3" : "R4 R5";
  endfunction

  function automatic int pick(int m, logic [31:0] r, bit imag);
    if (m >= 200 && m < 300) begin
      case (imag ? r[9:8] : r[1:0])
        2'd0: return 32767;
        2'd1: return -32768;
        2'd2: return -1;
        default: return 0;
      endcase
    end
    if (m >= 300 && m < 400) return (imag ? int'(r[10:8]) : int'(r[2:0])) - 3;
    return imag ? int'($signed(r[31:16])) : int'($signed(r[23:8]));
  endfunction

  task automatic check_lane(int i, int m);
    int l = lane_len(i);
    int u = m % (2 * l);
    int er, ei;
    bit sum;
    bit ok = 1'b1;
    if (u >= l) begin
      sum = 1'b1;
      er = (xr[m-l] + xr[m]) >>> 1;
      ei = (xi[m-l] + xi[m]) >>> 1;
    end else if (m >= 2 * l) begin
      sum = 1'b0;
      er = (xr[m-2*l] - xr[m-l]) >>> 1;
      ei = (xi[m-2*l] - xi[m-l]) >>> 1;
    end else begin
      ok = 1'b0;
    end
    if (ok) begin
      check(tag_for(i, m, sum), i, int'(ore[i]), er);
      check("R9", i, int'(oim[i]), ei);
    end
  endtask

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    logic [5:0]  dn  = 6'h3f;
    int  n = 0;
    bit  prev_valid = 1'b0;
    int  prev_n = 0;

    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      check("R1", i, int'(ov[i]), 0);
      check("R1", i, int'(ore[i]), 0);
      last_re[i] = 0;
      last_im[i] = 0;
    end
    rst = 1'b0;

    while (n < NSMP || prev_valid) begin
      if (n > 0 || prev_valid) begin
        for (int i = 0; i < NL; i++) begin
          check("R2", i, int'(ov[i]), int'(prev_valid));
          if (prev_valid) begin
            check_lane(i, prev_n);
          end else begin
            check("R2", i, int'(ore[i]), last_re[i]);
            check("R2", i, int'(oim[i]), last_im[i]);
          end
          last_re[i] = int'(ore[i]);
          last_im[i] = int'(oim[i]);
        end
      end
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (n < NSMP && !(n >= 400 && lcg[30:29] == 2'd0)) begin
        xr[n] = pick(n, lcg, 1'b0);
        xi[n] = pick(n, lcg, 1'b1);
        in_valid = 1'b1;
        in_re = W'(xr[n]);
        in_im = W'(xi[n]);
        for (int i = 0; i < NL; i++) fh[i] = dn[lane_bit(i)];
        prev_valid = 1'b1;
        prev_n = n;
        n++;
        dn = dn - 6'd1;
      end else begin
        in_valid = 1'b0;
        in_re = W'(lcg[15:0]);
        in_im = W'(lcg[31:16]);
        prev_valid = 1'b0;
      end
      @(negedge clk);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule